// File: doc/BRIEF.md
# Bit-Slip Word Boundary Realigner

This block follows a 1:W deserializer and moves the word boundary of the parallel data it produces. On every parallel-clock cycle it takes in a W-bit word and keeps the word from the cycle before. It joins the two words and passes on a W-bit window of the result. Where that window starts is set by an internal bit offset. Each rising edge on the slip request input adds one bit to the offset. The offset goes from W-1 back to 0, so W slips bring the alignment back to where it started.

The realigned word appears after a fixed pipeline of four parallel-clock cycles. A valid flag goes low when a slip is accepted. It comes back high on exactly the cycle in which the output first carries data built with the new offset. Training logic upstream can therefore pulse the slip input and wait for the valid flag before it judges the new alignment.

Top module: `word_realign`

## Requirements
- R1: A synchronous active-high reset sets the offset to 0 and clears the edge detector, the previous-word register and the output pipeline. While reset is high and on the cycle after it, `dout` is all zeros and `dout_valid` is 0.
- R2: At offset 0, `dout` equals the `din` word sampled four clock edges earlier.
- R3: At offset k, the output window is built from two words. Bits [k-1:0] are bits [W-1:W-k] of the previous word. Bits [W-1:k] are bits [W-k-1:0] of the current word. For constant input data D, this gives D rotated left by k.
- R4: A slip is requested only when `slip_req` is seen high at a clock edge after being seen low at the edge before it. Holding `slip_req` high moves the offset by one position only.
- R5: Each accepted slip adds exactly one to the offset. The offset wraps from W-1 to 0, so W slips restore the original alignment.
- R6: `dout_valid` is 0 on the four cycles after the clock edge that accepts a slip. It returns to 1 after the fourth following edge. At that point `dout` already reflects the new offset.
- R7: A slip accepted while an earlier slip is still settling is counted. The four-cycle low window of `dout_valid` then restarts from the newest slip.
- R8: A request pulse that is high for one cycle, followed by a gap that is low for one cycle, is accepted as separate slips.
- R9: From `din` to `dout` the latency is four cycles at every offset. This holds whether or not `dout_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| slip_req | input | 1 | Slip request; each rising edge shifts the boundary by one bit |
| din | input | W | Parallel word from the deserializer |
| dout | output | W | Realigned word, four cycles after `din` |
| dout_valid | output | 1 | High once the current alignment has settled |

## Verification
The bench first runs random words at offset 0. This separates a correct four-cycle delay from an off-by-one pipeline. Next, a constant word with a distinct bit pattern is used, so each offset gives a different rotation. This exposes wrong shift direction, wrong slip counting and wrong wrap-around. Slip input patterns cover a single pulse, a long held level, back-to-back single-cycle pulses and a retrigger during settling. These show edge versus level detection, acceptance of minimum pulses and restart of the valid window. A long run of random words with random slip requests is then compared every cycle against a behavioural model. This catches mismatches in the window bits between the current and previous word.

// File: rtl/realign_pkg.sv
package realign_pkg;

    localparam int unsigned SETTLE_CYCLES = 4;

    typedef enum logic {
        ALIGN_SETTLING = 1'b0,
        ALIGN_STABLE   = 1'b1
    } align_state_e;

    function automatic int unsigned wrap_next(int unsigned k, int unsigned n);
        return (k + 1 >= n) ? 0 : k + 1;
    endfunction

endpackage

// File: rtl/slip_edge_detect.sv
module slip_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic slip_req,
    output logic slip_edge
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (rst) req_q <= 1'b0;
        else     req_q <= slip_req;
    end

    assign slip_edge = slip_req & ~req_q;

    // an edge needs a low sample first, so two edges never follow each other
    p_no_double_edge_r4: assert property (@(posedge clk) disable iff (rst)
        slip_edge |=> !slip_edge);
endmodule

// File: rtl/slip_offset_ctr.sv
module slip_offset_ctr #(
    parameter int unsigned W  = 8,
    localparam int unsigned OW = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [OW-1:0] offset
);
    import realign_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)       offset <= '0;
        else if (step) offset <= OW'(wrap_next(int'(offset), W));
    end
endmodule

// File: rtl/slip_window_sel.sv
module slip_window_sel #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned OW   = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  din,
    input  logic [OW-1:0] offset,
    output logic [W-1:0]  dout
);
    logic [W-1:0]   prev_word;
    logic [2*W-1:0] joined;
    logic [2*W-1:0] shifted;
    logic [W-1:0]   window;
    logic [W-1:0]   stage [DEPTH];

    always_comb begin
        joined  = {din, prev_word};
        shifted = joined >> (W - int'(offset));
        window  = shifted[W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_word <= '0;
        else     prev_word <= din;
    end

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= window;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign dout = stage[DEPTH-1];

    // offset 0 passes the current word straight into the pipeline
    p_zero_offset_r2: assert property (@(posedge clk) disable iff (rst)
        (offset == '0) |=> (stage[0] == $past(din)));
endmodule

// File: rtl/slip_settle_timer.sv
module slip_settle_timer #(
    parameter int unsigned SETTLE = 4,
    localparam int unsigned CW    = $clog2(SETTLE + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic settled
);
    import realign_pkg::*;

    logic [CW-1:0] remain;
    align_state_e  state;

    always_ff @(posedge clk) begin
        if (rst || restart)    remain <= CW'(SETTLE);
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign state   = (remain == '0) ? ALIGN_STABLE : ALIGN_SETTLING;
    assign settled = (state == ALIGN_STABLE);

    // once settled, only a new slip can drop the flag
    p_valid_holds_r7: assert property (@(posedge clk) disable iff (rst)
        (settled && !restart) |=> settled);
    p_restart_low_r7: assert property (@(posedge clk) disable iff (rst)
        restart |=> !settled);
endmodule

// File: rtl/word_realign.sv
module word_realign #(
    parameter int unsigned W      = 8,
    parameter int unsigned SETTLE = realign_pkg::SETTLE_CYCLES,
    localparam int unsigned OW    = (W > 1) ? $clog2(W) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         slip_req,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dout_valid
);
    logic          slip_edge;
    logic [OW-1:0] offset;

    slip_edge_detect u_edge (
        .clk       (clk),
        .rst       (rst),
        .slip_req  (slip_req),
        .slip_edge (slip_edge)
    );

    slip_offset_ctr #(.W(W)) u_offset (
        .clk    (clk),
        .rst    (rst),
        .step   (slip_edge),
        .offset (offset)
    );

    slip_window_sel #(.W(W), .DEPTH(SETTLE)) u_window (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .offset (offset),
        .dout   (dout)
    );

    slip_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (slip_edge),
        .settled (dout_valid)
    );

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!dout_valid && dout == '0 && offset == '0));

    p_step_one_r5: assert property (@(posedge clk) disable iff (rst)
        slip_edge |=> (offset == (($past(offset) == OW'(W-1)) ? '0 : $past(offset) + 1'b1)));

    p_level_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        !slip_edge |=> $stable(offset));

    p_slip_invalidates_r6: assert property (@(posedge clk) disable iff (rst)
        slip_edge |=> !dout_valid);
endmodule

// File: tb/test_word_realign.sv
module test_word_realign;
    localparam int W   = 8;
    localparam int LAT = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         slip_req = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         dout_valid;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    word_realign #(.W(W)) i_word_realign (
        .clk(clk), .rst(rst), .slip_req(slip_req), .din(din),
        .dout(dout), .dout_valid(dout_valid)
    );

    // ---------------- behavioural reference ----------------
    logic [W-1:0] m_q[$];
    logic [W-1:0] m_prev;
    int           m_off;
    int           m_cnt;
    bit           m_req_q;

    function automatic logic [W-1:0] ref_window(logic [W-1:0] cur, logic [W-1:0] prv, int k);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            int idx = i + W - k;
            r[i] = (idx < W) ? prv[idx] : cur[idx - W];
        end
        return r;
    endfunction

    function automatic logic [W-1:0] rotl(logic [W-1:0] d, int k);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = d[(i - k + W) % W];
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_q = {};
            for (int i = 0; i < LAT; i++) m_q.push_back('0);
            m_prev  = '0;
            m_off   = 0;
            m_cnt   = LAT;
            m_req_q = 1'b0;
        end else begin
            m_q.push_back(ref_window(din, m_prev, m_off));
            void'(m_q.pop_front());
            m_prev = din;
            if (slip_req && !m_req_q) begin
                m_off = (m_off + 1) % W;
                m_cnt = LAT;
            end else if (m_cnt > 0) begin
                m_cnt = m_cnt - 1;
            end
            m_req_q = slip_req;
        end
    end

    // every-cycle comparison (R2, R3, R9 data; R6 valid)
    always @(negedge clk) begin
        if (!rst && m_q.size() == LAT) begin
            total++;
            if (dout !== m_q[0]) begin
                bad++;
                $display("FAIL R3/R9 data: dout=%h expected=%h at %0t", dout, m_q[0], $time);
            end
            total++;
            if (dout_valid !== (m_cnt == 0)) begin
                bad++;
                $display("FAIL R6 valid: dout_valid=%0b expected=%0b at %0t", dout_valid, (m_cnt == 0), $time);
            end
        end
    end

    task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    localparam logic [W-1:0] PAT = 8'hB4;
    bit done = 0;

    initial begin
        cycles(3);
        // R1: state during reset
        check("R1 dout in reset", dout, '0);
        check("R1 valid in reset", W'(dout_valid), '0);
        rst = 1'b0;
        cycles(1);
        check("R1 valid after reset", W'(dout_valid), '0);

        // R2: offset 0, random words
        for (int i = 0; i < 20; i++) begin
            din = W'($urandom);
            cycles(1);
        end
        check("R2 valid settled", W'(dout_valid), 1);

        // constant pattern, single pulse -> offset 1
        din = PAT;
        cycles(6);
        check("R2 offset0 constant", dout, PAT);
        slip_req = 1'b1; cycles(1); slip_req = 1'b0;
        cycles(3);
        check("R6 valid low on 4th cycle", W'(dout_valid), '0);
        cycles(1);
        check("R6 valid back", W'(dout_valid), 1);
        check("R6 new alignment when valid", dout, rotl(PAT, 1));

        // R4: held high -> only one slip
        slip_req = 1'b1;
        cycles(10);
        check("R4 held level one slip", dout, rotl(PAT, 2));
        check("R4 valid while held", W'(dout_valid), 1);
        slip_req = 1'b0;
        cycles(3);
        check("R4 falling edge ignored", dout, rotl(PAT, 2));

        // R8 / R5: six one-cycle pulses, one-cycle gaps -> offset 8 wraps to 0
        for (int p = 0; p < 6; p++) begin
            slip_req = 1'b1; cycles(1);
            slip_req = 1'b0; cycles(1);
        end
        cycles(5);
        check("R5 wrap to offset 0", dout, PAT);
        check("R8 short pulses all counted", W'(dout_valid), 1);

        // R7: retrigger during settling
        slip_req = 1'b1; cycles(1); slip_req = 1'b0; cycles(1);
        slip_req = 1'b1; cycles(1); slip_req = 1'b0;
        cycles(2);
        check("R7 window restarted", W'(dout_valid), '0);
        cycles(2);
        check("R7 valid after newest", W'(dout_valid), 1);
        check("R7 both slips counted", dout, rotl(PAT, 2));

        // R3 / R9: random words with random slip requests
        for (int i = 0; i < 400; i++) begin
            din = W'($urandom);
            slip_req = ($urandom % 5 == 0);
            cycles(1);
        end
        slip_req = 1'b0;
        cycles(6);

        // R1: reset mid-run
        rst = 1'b1; cycles(2);
        check("R1 dout cleared", dout, '0);
        rst = 1'b0; din = PAT; cycles(6);
        check("R1 offset back to 0", dout, PAT);
        done = 1;
    end

    initial begin
        int wd = 0;
        while (!done && wd < 20000) begin
            @(posedge clk);
            wd++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule